// File: doc/BRIEF.md
# Emulator Memory Access Port

This block gives an external in-circuit emulator direct access to the chip's internal RAM while the embedded controller is held in emulation mode. In that mode the chip is the slave. The emulator drives an address latch strobe, an active-low read strobe and an active-low write strobe. It puts the address on the upper address pins and on the multiplexed low address/data pins. The block captures the address and checks that it lies in the 4K window starting at zero. It then serves the read or write on its RAM and turns the shared data bus around only while a valid read is in progress.

The block also handles the type-0 interrupt pin. In emulation mode the pin is an open-drain output, pulled low whenever any internal source is active. In normal mode the pin is an active-low input, merged with the internal sources to form the core's active-low interrupt. Open-drain pins are modelled as an output enable with a constant-zero data value; the pull-up is external. All strobes are sampled on the block clock and are assumed to be synchronised already.

The block has no streaming data path, so it has no valid/ready interface. Every pin is a plain control or bus signal. Back-pressure does not apply: each strobe is served in the cycle it is seen.

Top module: `emu_mem_port`

## Requirements
- R1: In emulation mode, every clock edge with `ale_i` high captures the address {`addr_hi_i`, `ad_i`} (upper byte first). While `ale_i` is low the captured address holds.
- R2: An access hits only when the captured address is below 4096 (address bits 15:12 all zero). Addresses from 4096 up get no response: no write takes effect and `ad_oe` stays low.
- R3: `ad_oe` is high only while emulation mode is on, `rd_n_i` is low, `ale_i` is low and the captured address hits. In that same cycle `ad_o` shows the RAM byte at the captured address.
- R4: A write commits on the first clock edge where `wr_n_i` is seen high after being low. It stores the last `ad_i` value sampled while `wr_n_i` was low, and only if the address hits. A later read returns that byte.
- R5: `psen_oe` is low in emulation mode (pin high-impedance) and high in normal mode.
- R6: `xint_o` is always 0. In emulation mode `xint_oe` is high exactly when any bit of `irq_src_i` is set. In normal mode it is low.
- R7: `core_int0_n` is low exactly when any `irq_src_i` bit is set, or when normal mode is on and `xint_n_i` is low.
- R8: A change of `emu_mode` clears the captured address to 0, so a read without a new strobe then targets address 0.
- R9: Outside emulation mode the strobes have no effect: `ad_oe` stays low and no RAM write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emu_mode | input | 1 | 1 selects emulation mode, 0 normal mode |
| ale_i | input | 1 | Address latch strobe from the emulator, active high |
| addr_hi_i | input | 8 | Upper address byte pins |
| ad_i | input | 8 | Low address/data bus, input side |
| ad_o | output | 8 | Low address/data bus, read data driven out |
| ad_oe | output | 1 | Output enable for the low address/data bus |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| psen_oe | output | 1 | Output enable for the program store strobe pin |
| xint_n_i | input | 1 | External interrupt pin input side, active low |
| irq_src_i | input | 8 | Internal type-0 interrupt sources |
| xint_o | output | 1 | Interrupt pin data (constant 0, open drain) |
| xint_oe | output | 1 | Interrupt pin pull-down enable |
| core_int0_n | output | 1 | Merged active-low interrupt 0 to the core |

## Verification
The in-RTL assertions check on every cycle the pin-level rules. The bus is enabled only during an emulation read with the strobe low. The program strobe pin is released in emulation. The open-drain pin is enabled only in emulation. The external interrupt forces the core input in normal mode. The captured address changes only on a strobe or a mode change. Whether the right byte returns, whether out-of-window writes leave memory untouched, and whether a mode switch redirects a later read to address 0 are shown only by the bench's write/read sequences against its own memory model.

// File: rtl/emu_port_pkg.sv
package emu_port_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned WIN_BITS = 12;
  localparam int unsigned IRQ_N    = 8;
  localparam int unsigned HI_W     = ADDR_W - DATA_W;

  typedef logic [ADDR_W-1:0] emu_addr_t;
  typedef logic [DATA_W-1:0] emu_data_t;
endpackage

// File: rtl/emu_addr_latch.sv
module emu_addr_latch
  import emu_port_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned WB = WIN_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emu_mode,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q,
  output logic          win_hit
);
  logic mode_q;
  logic mode_chg;

  assign mode_chg = (emu_mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= emu_mode;
      if (mode_chg)
        addr_q <= '0;
      else if (emu_mode && ale_i)
        addr_q <= addr_in;
    end
  end

  assign win_hit = (addr_q[AW-1:WB] == '0);

  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> ($past(ale_i) || $past(mode_chg)));

  a_r8_clear_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (addr_q == '0));
endmodule

// File: rtl/emu_ram.sv
module emu_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/emu_irq_merge.sv
module emu_irq_merge #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emu_mode,
  input  logic         xint_n_i,
  input  logic [N-1:0] irq_src_i,
  output logic         xint_o,
  output logic         xint_oe,
  output logic         core_int0_n
);
  logic any_int;

  assign any_int     = |irq_src_i;
  assign xint_o      = 1'b0;
  assign xint_oe     = emu_mode & any_int;
  assign core_int0_n = ~(any_int | (~emu_mode & ~xint_n_i));

  a_r6_od_only_emu: assert property (@(posedge clk) disable iff (!rst_n)
    xint_oe |-> (emu_mode && irq_src_i != '0));

  a_r7_ext_forces_core: assert property (@(posedge clk) disable iff (!rst_n)
    (!emu_mode && !xint_n_i) |-> !core_int0_n);
endmodule

// File: rtl/emu_mem_port.sv
module emu_mem_port
  import emu_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emu_mode,
  input  logic              ale_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  output logic              psen_oe,
  input  logic              xint_n_i,
  input  logic [IRQ_N-1:0]  irq_src_i,
  output logic              xint_o,
  output logic              xint_oe,
  output logic              core_int0_n
);
  emu_addr_t addr_q;
  logic      win_hit;
  logic      wr_q;
  emu_data_t wdat_q;
  logic      wr_commit;

  emu_addr_latch #(.AW(ADDR_W), .WB(WIN_BITS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .emu_mode(emu_mode),
    .ale_i   (ale_i),
    .addr_in ({addr_hi_i, ad_i}),
    .addr_q  (addr_q),
    .win_hit (win_hit)
  );

  // Write strobe tracking: data is sampled while the strobe is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b1;
      wdat_q <= '0;
    end else begin
      wr_q <= wr_n_i | ~emu_mode;
      if (emu_mode && !wr_n_i)
        wdat_q <= ad_i;
    end
  end

  assign wr_commit = emu_mode & win_hit & wr_n_i & ~wr_q;

  emu_ram #(.DW(DATA_W), .AW(WIN_BITS)) u_ram (
    .clk  (clk),
    .we   (wr_commit),
    .waddr(addr_q[WIN_BITS-1:0]),
    .wdata(wdat_q),
    .raddr(addr_q[WIN_BITS-1:0]),
    .rdata(ad_o)
  );

  assign ad_oe   = emu_mode & win_hit & ~rd_n_i & ~ale_i;
  assign psen_oe = ~emu_mode;

  emu_irq_merge #(.N(IRQ_N)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .emu_mode   (emu_mode),
    .xint_n_i   (xint_n_i),
    .irq_src_i  (irq_src_i),
    .xint_o     (xint_o),
    .xint_oe    (xint_oe),
    .core_int0_n(core_int0_n)
  );

  a_r3_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (emu_mode && !rd_n_i && addr_q < (1 << WIN_BITS)));

  a_r5_psen_released: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |-> !psen_oe);

  a_r4_commit_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && !wr_n_i) |=> (!wr_commit || !$stable(wr_n_i)));

  a_r9_idle_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !emu_mode |-> (!ad_oe && !wr_commit));
endmodule

// File: tb/emu_mem_port_bench.sv
module emu_mem_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       emu_mode = 1'b1;
  logic       ale_i = 1'b0;
  logic [7:0] addr_hi_i = '0;
  logic [7:0] ad_i = '0;
  logic [7:0] ad_o;
  logic       ad_oe;
  logic       rd_n_i = 1'b1;
  logic       wr_n_i = 1'b1;
  logic       psen_oe;
  logic       xint_n_i = 1'b1;
  logic [7:0] irq_src_i = '0;
  logic       xint_o;
  logic       xint_oe;
  logic       core_int0_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [4096];
  logic       known [4096];

  always #4 clk = ~clk;

  emu_mem_port u_emu_mem_port (
    .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .ale_i(ale_i),
    .addr_hi_i(addr_hi_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .psen_oe(psen_oe),
    .xint_n_i(xint_n_i), .irq_src_i(irq_src_i), .xint_o(xint_o),
    .xint_oe(xint_oe), .core_int0_n(core_int0_n)
  );

  function automatic bit in_win(input logic [15:0] a);
    return a < 16'd4096;
  endfunction

  function automatic logic exp_core(input logic em, input logic x, input logic [7:0] s);
    return !((s != 0) || (!em && !x));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [15:0] a);
    @(negedge clk); ale_i = 1'b1; addr_hi_i = a[15:8]; ad_i = a[7:0];
    @(negedge clk); ale_i = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    latch(a);
    wr_n_i = 1'b0; ad_i = d;
    @(negedge clk); wr_n_i = 1'b1; ad_i = ~d;
    @(negedge clk);
    if (emu_mode && in_win(a)) begin model[a[11:0]] = d; known[a[11:0]] = 1'b1; end
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    latch(a);
    rd_n_i = 1'b0; #1;
    chk({req, " oe"}, ad_oe, emu_mode && in_win(a));
    if (in_win(a) && emu_mode && known[a[11:0]]) chk({req, " data"}, ad_o, model[a[11:0]]);
    @(negedge clk); rd_n_i = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) known[i] = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // Reset state
    chk("R3 reset oe", ad_oe, 0);
    chk("R5 psen emu", psen_oe, 0);
    chk("R6 xint_o", xint_o, 0);
    chk("R6 xint_oe idle", xint_oe, 0);

    // Directed window edges (R2, R4)
    do_write(16'h0000, 8'h11);
    do_write(16'h0FFF, 8'hEE);
    do_write(16'h1000, 8'h77);     // outside: must not alias to 0x000
    do_write(16'hF000, 8'h99);     // outside: must not alias to 0x000
    do_read(16'h0000, "R2 R4 low edge");
    do_read(16'h0FFF, "R4 top edge");
    do_read(16'h1000, "R2 outside");
    do_read(16'hFFFF, "R2 outside top");

    // R3: no drive while ALE high
    @(negedge clk); ale_i = 1'b1; addr_hi_i = 8'h00; ad_i = 8'h05; rd_n_i = 1'b0; #1;
    chk("R3 ale high", ad_oe, 0);
    @(negedge clk); ale_i = 1'b0; rd_n_i = 1'b1;

    // R1: address holds without ALE
    latch(16'h0FFF);
    ad_i = 8'h00; addr_hi_i = 8'h00;
    @(negedge clk); rd_n_i = 1'b0; #1;
    chk("R1 hold data", ad_o, 8'hEE);
    @(negedge clk); rd_n_i = 1'b1;

    // R8: mode switch clears latched address
    latch(16'h0FFF);
    @(negedge clk); emu_mode = 1'b0;
    @(negedge clk); #1;
    chk("R5 psen normal", psen_oe, 1);
    // R9: strobes ignored in normal mode
    ale_i = 1'b1; addr_hi_i = 8'h00; ad_i = 8'h00;
    @(negedge clk); ale_i = 1'b0; wr_n_i = 1'b0; ad_i = 8'h42;
    @(negedge clk); wr_n_i = 1'b1; rd_n_i = 1'b0; #1;
    chk("R9 normal oe", ad_oe, 0);
    @(negedge clk); rd_n_i = 1'b1; emu_mode = 1'b1;
    @(negedge clk); @(negedge clk); rd_n_i = 1'b0; #1;
    chk("R8 oe after switch", ad_oe, 1);
    chk("R8 R9 addr zero data", ad_o, 8'h11);
    @(negedge clk); rd_n_i = 1'b1;

    // Interrupt paths (R6, R7)
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        emu_mode = m[0];
        irq_src_i = ($urandom % 3 == 0) ? 8'h00 : 8'(1 << ($urandom % 8));
        xint_n_i = $urandom % 2;
        #1;
        chk("R6 xint_oe", xint_oe, emu_mode && irq_src_i != 0);
        chk("R7 core int", core_int0_n, exp_core(emu_mode, xint_n_i, irq_src_i));
      end
    end
    @(negedge clk); irq_src_i = '0; xint_n_i = 1'b1; emu_mode = 1'b1;
    @(negedge clk);

    // Random mix of accesses (R2, R3, R4)
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? 16'($urandom) : {4'h0, 12'($urandom % 64)};
      if ($urandom % 2) do_write(a, 8'($urandom));
      else do_read(a, "R3 R4 random");
    end
    for (int j = 0; j < 64; j++) if (known[j]) do_read(16'(j), "R4 sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule